// File: doc/BRIEF.md
# Monitor channel message receiver

This block takes in multi-byte messages carried one byte per frame on a serial monitor channel. Once per frame, marked by a one-cycle strobe, it samples the byte and the active-low transmit indication from the downstream line. It answers on the upstream line with an active-low acknowledge. Each byte is first sampled, then confirmed by a last look in the following frame: the same byte must be seen again while the transmit indication is still active. Only after that confirmation is the byte delivered.

The first confirmed byte of a message is an address. It has fixed bits and three variable bits. From those bits the block works out which of two channels the message goes to, or whether both receive it. It also works out whether the message is a channel-identification command or some other command. Confirmed bytes leave on a one-clock valid/data output, and the address byte carries a first flag. Separate one-clock pulses signal the end of a message and an abort. An internal abort request forces an abort from any state.

A message ends when the transmit indication stays inactive for a parameterised number of consecutive frames after a confirmed byte.

Top module: `mchan_rx`

## Requirements
- R1: In reset, `mr_n` is 1 and `out_valid`, `out_end` and `out_abort` are 0. `to_ch1`, `to_ch2` and `ident_cmd` are also 0.
- R2: While idle, `mr_n` stays 1. At a strobe with `mx_n`=0 the block captures `rx_byte` and delivers nothing yet. Strobes with `mx_n`=1 leave it idle.
- R3: At the strobe after a capture, the byte is confirmed if `mx_n` is 0 and `rx_byte` equals the captured byte. In the clock after that strobe edge, `out_valid` is 1 with `out_data` holding the byte, and `mr_n` is 0 until the next strobe.
- R4: The first byte of a message is accepted only if bits 7..5 equal 100 and bits 2..1 equal 00. It is delivered with `out_first`=1. Any other first byte causes an abort.
- R5: On the first byte, bit 4 is A, bit 3 is B and bit 0 is C. When it is accepted, `to_ch1` becomes B or not A, `to_ch2` becomes B or A, and `ident_cmd` becomes not C. These outputs hold until the next address byte is accepted.
- R6: A last look with `mx_n`=1, or with a byte that differs from the capture, causes an abort. An abort gives a one-clock `out_abort` pulse and holds `mr_n` at 0 for one frame. The block then returns to idle at the next strobe.
- R7: `abort_req`=1 at a strobe forces an abort from any state and takes priority over every other event.
- R8: After a confirmed byte, GAP_FRAMES consecutive strobes with `mx_n`=1 give a one-clock `out_end` pulse and return the block to idle, with `mr_n` back at 1. A strobe with `mx_n`=0 before that captures the next payload byte, which is delivered with `out_first`=0.
- R9: Outputs change only in the clock after a strobe edge. `out_valid`, `out_end` and `out_abort` last one clock, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle frame strobe |
| rx_byte | input | 8 | Byte received in the current frame |
| mx_n | input | 1 | Active-low transmit indication from downstream |
| abort_req | input | 1 | Internal abort request, acted on at a strobe |
| mr_n | output | 1 | Active-low acknowledge sent upstream |
| out_valid | output | 1 | One-clock pulse: confirmed byte on `out_data` |
| out_data | output | 8 | Confirmed byte |
| out_first | output | 1 | Confirmed byte is the address byte |
| out_end | output | 1 | One-clock pulse: message ended |
| out_abort | output | 1 | One-clock pulse: message aborted |
| to_ch1 | output | 1 | Message is routed to channel 1 |
| to_ch2 | output | 1 | Message is routed to channel 2 |
| ident_cmd | output | 1 | Message is a channel-identification command |

## Verification
The bench builds the block with GAP_FRAMES set to 3 rather than the default of 2. A message that pauses for two inactive frames and then sends another byte must therefore continue, while three inactive frames end it. This separates the end-of-message count from the single idle frame that normally sits between bytes. The bench also drives strobes every fourth clock, so the quiet clocks between strobes are checked for changes that should not happen.

// File: rtl/mchan_rx_pkg.sv
package mchan_rx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_NTH,
        ST_WAIT,
        ST_ABORT
    } rx_state_e;

    typedef struct packed {
        logic to_ch1;
        logic to_ch2;
        logic ident;
    } route_t;

    localparam logic [BYTE_W-1:0] ADDR_MASK  = 8'hE6;
    localparam logic [BYTE_W-1:0] ADDR_FIXED = 8'h80;

    function automatic logic addr_ok(input logic [BYTE_W-1:0] b);
        return (b & ADDR_MASK) == ADDR_FIXED;
    endfunction

    function automatic route_t addr_route(input logic [BYTE_W-1:0] b);
        route_t r;
        r.to_ch1 = b[3] | ~b[4];
        r.to_ch2 = b[3] | b[4];
        r.ident  = ~b[0];
        return r;
    endfunction

endpackage

// File: rtl/mchan_rx_sampler.sv
module mchan_rx_sampler
    import mchan_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] held,
    output logic              match
);
    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (load) held <= rx_byte;
    end

    assign match = (rx_byte == held);
endmodule

// File: rtl/mchan_rx_gap.sv
module mchan_rx_gap #(
    parameter int GAP_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(GAP_FRAMES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(GAP_FRAMES - 1));
endmodule

// File: rtl/mchan_rx_ctrl.sv
module mchan_rx_ctrl
    import mchan_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic              mx_n,
    input  logic              abort_req,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] held,
    input  logic              match,
    input  logic              gap_last,
    output logic              load,
    output logic              gap_clr,
    output logic              gap_inc,
    output logic              mr_n,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_first,
    output logic              out_end,
    output logic              out_abort,
    output route_t            route
);
    rx_state_e state, state_nx;
    logic      accept, bad, go_abort, finish;

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        accept   = 1'b0;
        go_abort = 1'b0;
        finish   = 1'b0;
        gap_inc  = 1'b0;
        bad      = mx_n || !match || (state == ST_FIRST && !addr_ok(rx_byte));
        if (frame_stb) begin
            if (abort_req) begin
                go_abort = 1'b1;
            end else begin
                unique case (state)
                    ST_IDLE: if (!mx_n) begin
                        load     = 1'b1;
                        state_nx = ST_FIRST;
                    end
                    ST_FIRST, ST_NTH: begin
                        if (bad) go_abort = 1'b1;
                        else begin
                            accept   = 1'b1;
                            state_nx = ST_WAIT;
                        end
                    end
                    ST_WAIT: begin
                        if (!mx_n) begin
                            load     = 1'b1;
                            state_nx = ST_NTH;
                        end else if (gap_last) begin
                            finish   = 1'b1;
                            state_nx = ST_IDLE;
                        end else begin
                            gap_inc  = 1'b1;
                        end
                    end
                    ST_ABORT: state_nx = ST_IDLE;
                    default:  state_nx = ST_IDLE;
                endcase
            end
            if (go_abort) state_nx = ST_ABORT;
        end
    end

    assign gap_clr = accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mr_n      <= 1'b1;
            out_valid <= 1'b0;
            out_end   <= 1'b0;
            out_abort <= 1'b0;
            out_data  <= '0;
            out_first <= 1'b0;
            route     <= '0;
        end else begin
            state     <= state_nx;
            out_valid <= accept;
            out_end   <= finish;
            out_abort <= go_abort;
            if (frame_stb) mr_n <= !(accept || go_abort);
            if (accept) begin
                out_data  <= held;
                out_first <= (state == ST_FIRST);
                if (state == ST_FIRST) route <= addr_route(held);
            end
        end
    end
endmodule

// File: rtl/mchan_rx.sv
module mchan_rx
    import mchan_rx_pkg::*;
#(
    parameter int GAP_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_stb,
    input  logic [7:0] rx_byte,
    input  logic       mx_n,
    input  logic       abort_req,
    output logic       mr_n,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_end,
    output logic       out_abort,
    output logic       to_ch1,
    output logic       to_ch2,
    output logic       ident_cmd
);
    logic [BYTE_W-1:0] held;
    logic              match, load, gap_clr, gap_inc, gap_last;
    route_t            route;

    mchan_rx_sampler u_smp (
        .clk(clk), .rst(rst), .load(load), .rx_byte(rx_byte),
        .held(held), .match(match)
    );

    mchan_rx_gap #(.GAP_FRAMES(GAP_FRAMES)) u_gap (
        .clk(clk), .rst(rst), .clr(gap_clr), .inc(gap_inc), .last(gap_last)
    );

    mchan_rx_ctrl u_ctl (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .mx_n(mx_n),
        .abort_req(abort_req), .rx_byte(rx_byte), .held(held), .match(match),
        .gap_last(gap_last), .load(load), .gap_clr(gap_clr), .gap_inc(gap_inc),
        .mr_n(mr_n), .out_valid(out_valid), .out_data(out_data),
        .out_first(out_first), .out_end(out_end), .out_abort(out_abort),
        .route(route)
    );

    assign to_ch1    = route.to_ch1;
    assign to_ch2    = route.to_ch2;
    assign ident_cmd = route.ident;
endmodule

// File: rtl/mchan_rx_chk.sv
module mchan_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_stb,
    input logic       mr_n,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_first,
    input logic       out_end,
    input logic       out_abort,
    input logic       to_ch1,
    input logic       to_ch2,
    input logic       ident_cmd
);
    // R9
    mr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_stb) |-> $stable(mr_n));
    // R9
    route_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_stb) |-> $stable({to_ch1, to_ch2, ident_cmd}));
    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, out_end, out_abort}));
    // R9
    valid_short_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R3
    valid_ack_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !mr_n);
    // R6
    abort_ack_chk: assert property (@(posedge clk) disable iff (rst)
        out_abort |-> !mr_n);
    // R8
    end_release_chk: assert property (@(posedge clk) disable iff (rst)
        out_end |-> mr_n);
    // R4
    addr_form_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_first) |-> ((out_data & 8'hE6) == 8'h80));
    // R5
    route_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_first) |->
            (to_ch1 == (out_data[3] || !out_data[4])) &&
            (to_ch2 == (out_data[3] || out_data[4])) &&
            (ident_cmd == !out_data[0]));
endmodule

bind mchan_rx mchan_rx_chk u_chk (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .mr_n(mr_n),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_end(out_end), .out_abort(out_abort), .to_ch1(to_ch1),
    .to_ch2(to_ch2), .ident_cmd(ident_cmd)
);

// File: tb/mchan_rx_test.sv
module mchan_rx_test;
    localparam int GAP = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       mx_n = 1'b1;
    logic       abort_req = 1'b0;
    logic       mr_n, out_valid, out_first, out_end, out_abort;
    logic       to_ch1, to_ch2, ident_cmd;
    logic [7:0] out_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mchan_rx #(.GAP_FRAMES(GAP)) uut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .rx_byte(rx_byte),
        .mx_n(mx_n), .abort_req(abort_req), .mr_n(mr_n),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_end(out_end), .out_abort(out_abort), .to_ch1(to_ch1),
        .to_ch2(to_ch2), .ident_cmd(ident_cmd)
    );

    // behavioural reference: phase 0 idle, 1 address sampled, 2 payload
    // sampled, 3 between bytes, 4 aborting
    int         ph = 0;
    int         quiet = 0;
    logic [7:0] keep = 8'h00;
    logic       e_mr = 1'b1, e_val = 1'b0, e_end = 1'b0, e_ab = 1'b0;
    logic       e_first = 1'b0, e_c1 = 1'b0, e_c2 = 1'b0, e_id = 1'b0;
    logic [7:0] e_data = 8'h00;

    function automatic bit addr_shape(input logic [7:0] b);
        return b[7] == 1'b1 && b[6] == 1'b0 && b[5] == 1'b0 &&
               b[2] == 1'b0 && b[1] == 1'b0;
    endfunction

    always @(posedge clk) begin
        e_val = 1'b0; e_end = 1'b0; e_ab = 1'b0;
        if (rst) begin
            ph = 0; quiet = 0; e_mr = 1'b1;
            e_c1 = 1'b0; e_c2 = 1'b0; e_id = 1'b0;
        end else if (frame_stb) begin
            if (abort_req) begin
                ph = 4; e_mr = 1'b0; e_ab = 1'b1;
            end else if (ph == 0) begin
                if (!mx_n) begin keep = rx_byte; ph = 1; end
            end else if (ph == 1 || ph == 2) begin
                if (mx_n || rx_byte != keep || (ph == 1 && !addr_shape(rx_byte))) begin
                    ph = 4; e_mr = 1'b0; e_ab = 1'b1;
                end else begin
                    e_val = 1'b1; e_data = keep; e_first = (ph == 1); e_mr = 1'b0;
                    if (ph == 1) begin
                        if (keep[3]) begin e_c1 = 1'b1; e_c2 = 1'b1; end
                        else if (keep[4]) begin e_c1 = 1'b0; e_c2 = 1'b1; end
                        else begin e_c1 = 1'b1; e_c2 = 1'b0; end
                        e_id = (keep[0] == 1'b0);
                    end
                    ph = 3; quiet = 0;
                end
            end else if (ph == 3) begin
                e_mr = 1'b1;
                if (!mx_n) begin keep = rx_byte; ph = 2; end
                else begin
                    quiet++;
                    if (quiet >= GAP) begin e_end = 1'b1; ph = 0; end
                end
            end else begin
                e_mr = 1'b1; ph = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: got %h expected %h", tag, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            chk("R2/R3/R6 mr_n", {7'b0, mr_n}, {7'b0, e_mr});
            chk("R3 out_valid", {7'b0, out_valid}, {7'b0, e_val});
            chk("R8 out_end", {7'b0, out_end}, {7'b0, e_end});
            chk("R6/R7 out_abort", {7'b0, out_abort}, {7'b0, e_ab});
            chk("R5 route", {5'b0, to_ch1, to_ch2, ident_cmd}, {5'b0, e_c1, e_c2, e_id});
            if (e_val) begin
                chk("R3 out_data", out_data, e_data);
                chk("R4/R8 out_first", {7'b0, out_first}, {7'b0, e_first});
            end
        end
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic frame(input logic mx, input logic [7:0] b, input logic ab = 1'b0);
        @(negedge clk);
        mx_n = mx; rx_byte = b; abort_req = ab; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0; abort_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        frame(1'b0, b); frame(1'b0, b); frame(1'b1, 8'h00);
    endtask

    task automatic close();
        repeat (GAP) frame(1'b1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 mr_n", {7'b0, mr_n}, 8'h01);
        chk("R1 pulses", {5'b0, out_valid, out_end, out_abort}, 8'h00);
        chk("R1 route", {5'b0, to_ch1, to_ch2, ident_cmd}, 8'h00);
        rst = 1'b0;
        // R2 idle frames
        frame(1'b1, 8'h80); frame(1'b1, 8'h91);
        // R5 ch1 ident, one payload, end
        send(8'h80); send(8'h55); close();
        // R5 ch2 other, back-to-back payload bytes
        frame(1'b0, 8'h91); frame(1'b0, 8'h91);
        frame(1'b0, 8'hA1); frame(1'b0, 8'hA1);
        frame(1'b0, 8'h3C); frame(1'b0, 8'h3C); close();
        // R5 broadcast, R8 pause shorter than GAP keeps message open
        send(8'h89); frame(1'b1, 8'h00); frame(1'b0, 8'h77); frame(1'b0, 8'h77);
        chk("R5 broadcast", {5'b0, to_ch1, to_ch2, ident_cmd}, 8'b110);
        close();
        send(8'h99); close();
        // R4 bad address
        frame(1'b0, 8'hC0); frame(1'b0, 8'hC0); frame(1'b1, 8'h00);
        frame(1'b0, 8'h86); frame(1'b0, 8'h86); frame(1'b1, 8'h00);
        // R6 mismatch and MX drop at last look
        send(8'h80); frame(1'b0, 8'h12); frame(1'b0, 8'h13); frame(1'b1, 8'h00);
        send(8'h81); frame(1'b0, 8'h44); frame(1'b1, 8'h44); frame(1'b1, 8'h00);
        // R7 abort request between bytes, in idle, and during last look
        send(8'h90); frame(1'b1, 8'h00, 1'b1); frame(1'b1, 8'h00);
        frame(1'b1, 8'h00, 1'b1); frame(1'b0, 8'h80);
        frame(1'b1, 8'h00); frame(1'b1, 8'h00);
        frame(1'b0, 8'h88); frame(1'b0, 8'h88, 1'b1); frame(1'b1, 8'h00);
        // recovery after abort
        send(8'h98); send(8'hFF); close();
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule